// File: doc/BRIEF.md
# Grouped Four-Level Interrupt Priority Controller

This block sits between up to eighteen peripheral interrupt lines and a CPU core. Each line sets a pending flag. The flag holds until software clears it. The lines are gathered into six groups of three, and every group is given one of four priority levels. Software programs the levels through two byte-wide level registers, one holding the low bit of each group's level and the other the high bit. An arbiter picks the pending source with the highest level that is allowed to run. It then presents a registered request, the source's vector index and the level to the core.

The core answers with an acknowledge strobe, which marks the presented level as in service. At the end of its handler it sends a return strobe, which retires the most recent level. A four-bit stack of levels in service allows nesting, so only a strictly higher level can interrupt a running handler. A small byte register port gives access to the flags, the level registers and a control register. The low level register also carries a watchdog status flag and a free user bit.

Top module: `grp_irq_ctrl`

## Requirements
- R1: A high cycle on `src_irq[s]` sets pending flag s. The flag stays set until software writes 1 to its bit. Flag s reads at address s/8, bit s%8, and unused bits of address 2 read 0.
- R2: When a clear write and a hardware set hit the same flag in the same cycle, the flag ends up set.
- R3: Source s belongs to group s/3. Group g's level is {bit g of address 4, bit g of address 3}, where 0 is the lowest level and 3 the highest.
- R4: Among eligible pending sources, the highest level wins. Ties go to the lowest source index, so with both level registers at 0 the order is plain ascending index.
- R5: `irq_req`, `irq_vec` (source index) and `irq_lvl` are registered. They reflect the state after each clock edge, so a new flag or register write shows on the outputs one cycle later, and never before that edge.
- R6: `irq_ack` while `irq_req` is high marks `irq_lvl` as in service. A request is raised only for a level strictly above the highest level in service, or for any level when none is in service.
- R7: `irq_ret` clears the highest level in service. If `irq_ret` and `irq_ack` arrive together, the clear is applied first and the acknowledged level is then set.
- R8: Source 15 sets its flag only while control register (address 5) bit 0 is 1.
- R9: Address 3 bit 6 is a watchdog flag. `wdt_ovf` sets it, writing 0 clears it, and writing 1 leaves it unchanged. Bit 7 of address 3 is a plain read/write user bit.
- R10: Bits 7:6 of address 4, bits 7:1 of address 5 and all addresses above 5 read 0.
- R11: After reset, all flags, level registers, the control register and the in-service stack are 0, and `irq_req` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_irq | input | 18 | Peripheral interrupt lines, one per source |
| wdt_ovf | input | 1 | Watchdog overflow event |
| reg_addr | input | 3 | Register address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| irq_ack | input | 1 | Core accepts the presented request |
| irq_ret | input | 1 | Core leaves the current handler |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 5 | Index of the presented source |
| irq_lvl | output | 2 | Level of the presented source |

## Verification
The assertions check several rules on every cycle. A flag never drops without a clear write, and a hardware set always lands. A presented request always points at a pending flag and lies strictly above the highest level in service. An acknowledge sets its level bit, and a lone return removes exactly one level. Only the bench's scenarios can show which source wins under a given level programming, how ties follow index order, and how the stack behaves when acknowledge and return arrive together. The same is true of the gating of source 15, the write rules of the watchdog bit and the zero-reading register bits.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  localparam int IPC_NUM_GROUPS = 6;
  localparam int IPC_GROUP_SIZE = 3;
  localparam int IPC_DATA_W     = 8;
  localparam int IPC_ADDR_W     = 3;
  localparam int IPC_GATED_SRC  = 15;

  // highest set bit of an in-service mask (0 when empty)
  function automatic logic [1:0] ipc_top_level(input logic [3:0] act);
    logic [1:0] r;
    r = 2'd0;
    for (int i = 0; i < 4; i++) begin
      if (act[i]) r = 2'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/ipc_flags.sv
module ipc_flags #(
  parameter int NS    = 18,
  parameter int DW    = 8,
  parameter int GATED = 15,
  localparam int NB   = (NS + DW - 1) / DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0] src_irq,
  input  logic          gate_en,
  input  logic [NB-1:0] byte_clr,
  input  logic [DW-1:0] wdata,
  output logic [NS-1:0] pend_q,
  output logic [NS-1:0] pend_d
);
  logic [NS-1:0] set_v;
  logic [NS-1:0] clr_v;
  logic          upd;

  for (genvar s = 0; s < NS; s++) begin : g_src
    if (s == GATED) begin : g_gated
      assign set_v[s] = src_irq[s] & gate_en;
    end else begin : g_plain
      assign set_v[s] = src_irq[s];
    end
    assign clr_v[s] = byte_clr[s / DW] & wdata[s % DW];
  end

  always_comb begin
    pend_d = (pend_q & ~clr_v) | set_v;
    upd    = (|set_v) | (|byte_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pend_q <= '0;
    else if (upd) pend_q <= pend_d;
  end

  // R2
  set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_v) |=> ((pend_q & $past(set_v)) == $past(set_v)));

  // R1
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|byte_clr) |=> (($past(pend_q) & ~pend_q) == '0));
endmodule

// File: rtl/ipc_arbiter.sv
module ipc_arbiter #(
  parameter int NG  = 6,
  parameter int GS  = 3,
  localparam int NS = NG * GS,
  localparam int VW = $clog2(NS),
  localparam int LW = 2
) (
  input  logic [NS-1:0]    pend,
  input  logic [NG*LW-1:0] grp_lvl,
  input  logic [3:0]       active,
  output logic             hit,
  output logic [VW-1:0]    vec,
  output logic [LW-1:0]    lvl
);
  logic [LW-1:0] src_lvl [NS];
  logic [LW-1:0] floor_lvl;
  logic          busy;

  for (genvar s = 0; s < NS; s++) begin : g_lvl
    assign src_lvl[s] = grp_lvl[(s / GS) * LW +: LW];
  end

  always_comb begin
    busy      = |active;
    floor_lvl = ipc_pkg::ipc_top_level(active);
    hit = 1'b0;
    vec = '0;
    lvl = '0;
    for (int s = 0; s < NS; s++) begin
      if (pend[s] && (!busy || src_lvl[s] > floor_lvl) &&
          (!hit || src_lvl[s] > lvl)) begin
        hit = 1'b1;
        vec = VW'(s);
        lvl = src_lvl[s];
      end
    end
  end
endmodule

// File: rtl/ipc_level_stack.sv
module ipc_level_stack (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ret,
  input  logic       ack,
  input  logic [1:0] ack_lvl,
  output logic [3:0] act_q,
  output logic [3:0] act_d
);
  logic [3:0] top_mask;
  logic       en;

  always_comb begin
    top_mask = '0;
    for (int i = 0; i < 4; i++) begin
      if (act_q[i]) top_mask = 4'b0001 << i;
    end
    act_d = act_q;
    if (ret) act_d = act_d & ~top_mask;
    if (ack) act_d[ack_lvl] = 1'b1;
    en = ret | ack;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  act_q <= '0;
    else if (en) act_q <= act_d;
  end

  // R7
  pop_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && !ack && act_q != '0) |=> ($countones(act_q) == $countones($past(act_q)) - 1));

  // R6
  ack_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> act_q[$past(ack_lvl)]);
endmodule

// File: rtl/grp_irq_ctrl.sv
module grp_irq_ctrl #(
  parameter int NUM_GROUPS = ipc_pkg::IPC_NUM_GROUPS,
  parameter int GROUP_SIZE = ipc_pkg::IPC_GROUP_SIZE,
  parameter int DATA_W     = ipc_pkg::IPC_DATA_W,
  parameter int ADDR_W     = ipc_pkg::IPC_ADDR_W,
  parameter int GATED_SRC  = ipc_pkg::IPC_GATED_SRC,
  localparam int NS        = NUM_GROUPS * GROUP_SIZE,
  localparam int VW        = $clog2(NS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NS-1:0]     src_irq,
  input  logic              wdt_ovf,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              irq_ack,
  input  logic              irq_ret,
  output logic              irq_req,
  output logic [VW-1:0]     irq_vec,
  output logic [1:0]        irq_lvl
);
  localparam int NB     = (NS + DATA_W - 1) / DATA_W;
  localparam int A_LO   = NB;
  localparam int A_HI   = NB + 1;
  localparam int A_CTRL = NB + 2;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  // register file
  logic [NUM_GROUPS-1:0] lo_q, lo_d, hi_q, hi_d;
  logic user_q, user_d, wdt_q, wdt_d, gate_q, gate_d;
  logic we_lo, we_hi, we_ctrl, en_lo;
  logic [NB-1:0] byte_clr;

  for (genvar b = 0; b < NB; b++) begin : g_clr
    assign byte_clr[b] = reg_we & (reg_addr == ADDR_W'(b));
  end

  always_comb begin
    we_lo   = reg_we & (reg_addr == ADDR_W'(A_LO));
    we_hi   = reg_we & (reg_addr == ADDR_W'(A_HI));
    we_ctrl = reg_we & (reg_addr == ADDR_W'(A_CTRL));
    en_lo   = we_lo | wdt_ovf;
    lo_d    = we_lo   ? reg_wdata[NUM_GROUPS-1:0] : lo_q;
    hi_d    = we_hi   ? reg_wdata[NUM_GROUPS-1:0] : hi_q;
    user_d  = we_lo   ? reg_wdata[DATA_W-1] : user_q;
    wdt_d   = wdt_ovf | (wdt_q & ~(we_lo & ~reg_wdata[DATA_W-2]));
    gate_d  = we_ctrl ? reg_wdata[0] : gate_q;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      lo_q <= '0; user_q <= 1'b0; wdt_q <= 1'b0;
    end else if (en_lo) begin
      lo_q <= lo_d; user_q <= user_d; wdt_q <= wdt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)     hi_q <= '0;
    else if (we_hi) hi_q <= hi_d;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)       gate_q <= 1'b0;
    else if (we_ctrl) gate_q <= gate_d;
  end

  // pending flags
  logic [NS-1:0] pend_q, pend_d;
  ipc_flags #(.NS(NS), .DW(DATA_W), .GATED(GATED_SRC)) u_flags (
    .clk(clk), .rst_n(rst_s), .src_irq(src_irq), .gate_en(gate_q),
    .byte_clr(byte_clr), .wdata(reg_wdata), .pend_q(pend_q), .pend_d(pend_d)
  );

  // in-service stack
  logic       req_q;
  logic [VW-1:0] vec_q;
  logic [1:0] lvl_q;
  logic [3:0] act_q, act_d;
  ipc_level_stack u_stack (
    .clk(clk), .rst_n(rst_s), .ret(irq_ret), .ack(irq_ack & req_q),
    .ack_lvl(lvl_q), .act_q(act_q), .act_d(act_d)
  );

  // arbitration over the state that the coming edge will load
  logic [NUM_GROUPS*2-1:0] grp_lvl_d;
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    assign grp_lvl_d[g*2 +: 2] = {hi_d[g], lo_d[g]};
  end

  logic          win_hit;
  logic [VW-1:0] win_vec;
  logic [1:0]    win_lvl;
  ipc_arbiter #(.NG(NUM_GROUPS), .GS(GROUP_SIZE)) u_arb (
    .pend(pend_d), .grp_lvl(grp_lvl_d), .active(act_d),
    .hit(win_hit), .vec(win_vec), .lvl(win_lvl)
  );

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      req_q <= 1'b0; vec_q <= '0; lvl_q <= '0;
    end else begin
      req_q <= win_hit; vec_q <= win_vec; lvl_q <= win_lvl;
    end
  end

  assign irq_req = req_q;
  assign irq_vec = vec_q;
  assign irq_lvl = lvl_q;

  // read mux
  logic [NB*DATA_W-1:0] pend_pad;
  assign pend_pad = (NB*DATA_W)'(pend_q);

  always_comb begin
    reg_rdata = '0;
    for (int b = 0; b < NB; b++) begin
      if (reg_addr == ADDR_W'(b)) reg_rdata = pend_pad[b*DATA_W +: DATA_W];
    end
    if (reg_addr == ADDR_W'(A_LO))
      reg_rdata = {user_q, wdt_q, (DATA_W-2)'(lo_q)};
    if (reg_addr == ADDR_W'(A_HI))
      reg_rdata = DATA_W'(hi_q);
    if (reg_addr == ADDR_W'(A_CTRL))
      reg_rdata = DATA_W'(gate_q);
  end

  // R6
  req_above_chk: assert property (@(posedge clk) disable iff (!rst_s)
    req_q |-> (act_q == '0 || lvl_q > ipc_pkg::ipc_top_level(act_q)));

  // R5
  vec_pending_chk: assert property (@(posedge clk) disable iff (!rst_s)
    req_q |-> pend_q[vec_q]);

  // R9
  wdt_set_chk: assert property (@(posedge clk) disable iff (!rst_s)
    wdt_ovf |=> wdt_q);
endmodule

// File: tb/tb_grp_irq_ctrl.sv
module tb_grp_irq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [17:0] src_irq = '0;
  logic wdt_ovf = 1'b0;
  logic [2:0] reg_addr = '0;
  logic reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic irq_ack = 1'b0;
  logic irq_ret = 1'b0;
  logic irq_req;
  logic [4:0] irq_vec;
  logic [1:0] irq_lvl;

  always #10 clk = ~clk;

  grp_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .wdt_ovf(wdt_ovf),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_ack(irq_ack), .irq_ret(irq_ret),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_lvl(irq_lvl)
  );

  int n_chk = 0;
  int n_fail = 0;
  int last_rd;
  int pre_req;

  // reference model state
  bit [17:0] m_pend;
  bit [5:0]  m_lo, m_hi;
  bit        m_user, m_wdt, m_gate;
  bit [3:0]  m_act;
  int        m_req, m_vec, m_lvl;

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int m_read(input int a);
    case (a)
      0, 1, 2: return int'((m_pend >> (8 * a)) & 18'hFF);
      3: return {m_user, m_wdt, m_lo};
      4: return m_hi;
      5: return m_gate;
      default: return 0;
    endcase
  endfunction

  function automatic void m_arb();
    int fl, best, bl, l;
    fl = -1; best = -1; bl = 0;
    for (int i = 0; i < 4; i++) if (m_act[i]) fl = i;
    for (int s = 0; s < 18; s++) begin
      l = 2 * m_hi[s / 3] + m_lo[s / 3];
      if (m_pend[s] && l > fl && (best < 0 || l > bl)) begin
        best = s; bl = l;
      end
    end
    m_req = (best >= 0);
    m_vec = (best >= 0) ? best : 0;
    m_lvl = (best >= 0) ? bl : 0;
  endfunction

  // one clock: drive at negedge, check read and outputs, update model at edge
  task automatic step(input logic [17:0] irq, input logic wo, input logic we,
                      input logic [2:0] a, input logic [7:0] d,
                      input logic ak, input logic rt, input string tag);
    int top;
    src_irq = irq; wdt_ovf = wo; reg_we = we; reg_addr = a; reg_wdata = d;
    irq_ack = ak; irq_ret = rt;
    #1;
    last_rd = reg_rdata;
    pre_req = irq_req;
    chk(reg_rdata, m_read(a), {tag, " rdata"});
    @(posedge clk);
    top = -1;
    for (int i = 0; i < 4; i++) if (m_act[i]) top = i;
    if (rt && top >= 0) m_act[top] = 1'b0;
    if (ak && m_req != 0) m_act[m_lvl] = 1'b1;
    if (we && a <= 2) begin
      for (int i = 0; i < 8; i++)
        if (d[i] && (8 * a + i) < 18) m_pend[8 * a + i] = 1'b0;
    end
    for (int s = 0; s < 18; s++)
      if (irq[s] && (s != 15 || m_gate)) m_pend[s] = 1'b1;
    if (we && a == 3) begin m_lo = d[5:0]; m_user = d[7]; if (!d[6]) m_wdt = 1'b0; end
    if (wo) m_wdt = 1'b1;
    if (we && a == 4) m_hi = d[5:0];
    if (we && a == 5) m_gate = d[0];
    m_arb();
    @(negedge clk);
    chk(irq_req, m_req, {tag, " req"});
    chk(irq_vec, m_vec, {tag, " vec"});
    chk(irq_lvl, m_lvl, {tag, " lvl"});
    src_irq = '0; wdt_ovf = 1'b0; reg_we = 1'b0; irq_ack = 1'b0; irq_ret = 1'b0;
  endtask

  task automatic idle_rd(input logic [2:0] a, input string tag);
    step('0, 0, 0, a, 8'h00, 0, 0, tag);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input string tag);
    step('0, 0, 1, a, d, 0, 0, tag);
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    m_pend = '0; m_lo = '0; m_hi = '0; m_user = 0; m_wdt = 0; m_gate = 0;
    m_act = '0; m_req = 0; m_vec = 0; m_lvl = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) idle_rd(3'(i), "R11 idle");
    chk(irq_req, 0, "R11 req after reset");
    idle_rd(3, "R11");
    chk(last_rd, 0, "R11 level reg");

    // R1 / R5: single request, visible only after the edge
    step(18'h1 << 4, 0, 0, 0, 0, 0, 0, "R1 set");
    chk(pre_req, 0, "R5 before edge");
    chk(irq_req, 1, "R5 after edge");
    chk(irq_vec, 4, "R1 vec");
    idle_rd(0, "R1 read");
    chk(last_rd, 8'h10, "R1 flag byte");
    wr(0, 8'h10, "R1 clear");
    chk(irq_req, 0, "R1 cleared");

    // R4: ascending index among equal levels
    step((18'h1 << 10) | (18'h1 << 2) | (18'h1 << 7), 0, 0, 0, 0, 0, 0, "R4 tie");
    chk(irq_vec, 2, "R4 lowest index");

    // R3: group levels from two registers
    wr(3, 8'h08, "R3 lo");
    chk(irq_vec, 10, "R3 group3 vec");
    chk(irq_lvl, 1, "R3 group3 lvl");
    wr(4, 8'h04, "R3 hi");
    chk(irq_vec, 7, "R3 group2 vec");
    chk(irq_lvl, 2, "R3 group2 lvl");

    // R6: acknowledge and preemption
    step('0, 0, 0, 0, 0, 1, 0, "R6 ack");
    chk(irq_req, 0, "R6 masked at or below");
    wr(4, 8'h14, "R6 hi");
    wr(3, 8'h18, "R6 lo");
    step(18'h1 << 13, 0, 0, 0, 0, 0, 0, "R6 higher");
    chk(irq_vec, 13, "R6 preempt vec");
    chk(irq_lvl, 3, "R6 preempt lvl");
    step('0, 0, 0, 0, 0, 1, 0, "R6 nest ack");
    chk(irq_req, 0, "R6 nested");

    // R7: return and combined return+ack
    step('0, 0, 0, 0, 0, 0, 1, "R7 ret");
    chk(irq_vec, 13, "R7 re-request");
    step('0, 0, 0, 0, 0, 1, 1, "R7 ret+ack");
    chk(irq_req, 0, "R7 ret then ack");
    step('0, 0, 0, 0, 0, 0, 1, "R7 ret empty");
    chk(irq_req, 1, "R7 stack empty");
    wr(0, 8'hFF, "R7 clr0");
    wr(1, 8'hFF, "R7 clr1");
    wr(2, 8'hFF, "R7 clr2");
    chk(irq_req, 0, "R7 all cleared");

    // R2: clear and set collide
    step(18'h1 << 1, 0, 1, 0, 8'h02, 0, 0, "R2 collide");
    chk(irq_vec, 1, "R2 set wins");
    chk(irq_req, 1, "R2 req");
    wr(0, 8'h02, "R2 clear");

    // R8: gated source
    step(18'h1 << 15, 0, 0, 0, 0, 0, 0, "R8 gated off");
    idle_rd(1, "R8 read");
    chk(last_rd, 0, "R8 ignored");
    chk(irq_req, 0, "R8 no req");
    wr(5, 8'h01, "R8 enable");
    step(18'h1 << 15, 0, 0, 0, 0, 0, 0, "R8 gated on");
    chk(irq_vec, 15, "R8 vec");
    idle_rd(1, "R8 read on");
    chk(last_rd, 8'h80, "R8 flag");

    // R9: watchdog and user bits
    step('0, 1, 0, 0, 0, 0, 0, "R9 ovf");
    idle_rd(3, "R9 read");
    chk(last_rd, 8'h58, "R9 set");
    wr(3, 8'hD8, "R9 write1");
    idle_rd(3, "R9 read2");
    chk(last_rd, 8'hD8, "R9 keep and user");
    wr(3, 8'h98, "R9 write0");
    idle_rd(3, "R9 read3");
    chk(last_rd, 8'h98, "R9 cleared");

    // R10: zero-reading bits
    wr(4, 8'hFF, "R10 hi");
    idle_rd(4, "R10 read hi");
    chk(last_rd, 8'h3F, "R10 hi upper");
    wr(5, 8'hFF, "R10 ctrl");
    idle_rd(5, "R10 read ctrl");
    chk(last_rd, 8'h01, "R10 ctrl upper");
    idle_rd(6, "R10 read unused");
    chk(last_rd, 0, "R10 unused addr");
    idle_rd(2, "R10 read flags2");
    chk(last_rd, 0, "R1 unused flag bits");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule